// File: doc/BRIEF.md
# I2C Target Register Write Front End

This block is the write side of a small I2C target. It watches oversampled SCL and SDA lines, finds START, repeated START and STOP conditions, and shifts in bytes most significant bit first. A transfer opens with an address byte. Its upper four bits are fixed, and its next three bits come from strap pins. If that address matches on a write, the next byte is taken as a register pointer. Data bytes that follow the pointer go into the register the pointer selects. Each accepted byte is acknowledged by driving an open-drain SDA enable low during the ninth clock.

There are three writable registers. One is an 8-bit configuration register. The other two are 16-bit threshold registers, a low (hysteresis) limit and a high (over-limit) limit. Their values, and the pointer held for a later read, appear on parallel outputs. The read data path and clock stretching are handled elsewhere.

Top module: `i2c_regwr_target`

## Requirements
- R1: An address byte whose upper seven bits equal 1001 followed by `strap_i[2:0]`, with its last bit (R/W) 0, is acknowledged: `sda_oe_o` is 1 while SCL is high in the ninth clock. Any other address gets no acknowledge, and the block then ignores the bus (no acknowledge, no register change) until the next START.
- R2: The byte after a matched address is stored in `ptr_o` and acknowledged. A transfer that ends with STOP right after the pointer changes no data register.
- R3: With pointer 0x01, the first data byte is written to `cfg_o` and acknowledged.
- R4: Pointer 0x02 selects `hyst_o` and pointer 0x03 selects `otemp_o`. The first data byte is the upper byte. Both bytes are written together only after the second byte completes, so a transfer that stops after one byte leaves the old value in place.
- R5: Data bytes beyond the selected register's width (past one byte for configuration, past two for a threshold) are acknowledged but change no register.
- R6: A repeated START begins a new address and pointer sequence, so a single bus session can write two different registers.
- R7: A pointer value other than 0x01, 0x02 or 0x03 is stored in `ptr_o`. Data bytes sent after it are acknowledged and discarded.
- R8: After reset `cfg_o` = 0x00, `hyst_o` = 0x4B00, `otemp_o` = 0x5000, `ptr_o` = 0x00, and `sda_oe_o` = 0.
- R9: `sda_oe_o` only becomes active while the synchronised SCL is low.
- R10: A matching address with R/W = 1 is not acknowledged, and the data bytes that follow it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Low three address bits from board straps |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| ptr_o | output | 8 | Stored register pointer |
| cfg_o | output | 8 | Configuration register |
| hyst_o | output | 16 | Hysteresis threshold register |
| otemp_o | output | 16 | Over-limit threshold register |

## Verification
The hardest case to reach from the pins is a threshold register that holds half of a new value: its first data byte has been taken but the second has not. The bench reaches that state by bit-banging a transfer that stops after one data byte. It then checks that the old value is still on the output. It also sends a repeated START straight after a configuration write and a run of surplus bytes, which shows that the byte counter restarts only when a new pointer arrives.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    localparam logic [3:0] DEV_ID_HI     = 4'b1001;
    localparam int         BYTE_W        = 8;
    localparam int         STRAP_W       = 3;
    localparam logic [7:0] PTR_CFG       = 8'h01;
    localparam logic [7:0] PTR_WIDE_BASE = 8'h02;
    localparam int         NUM_WIDE      = 2;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_p;
        logic                   sda_p;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.scl_sh = {s_q.scl_sh[SYNC_STAGES-2:0], scl_i};
        s_d.sda_sh = {s_q.sda_sh[SYNC_STAGES-2:0], sda_i};
        s_d.scl_p  = s_q.scl_sh[SYNC_STAGES-1];
        s_d.sda_p  = s_q.sda_sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{scl_sh: '1, sda_sh: '1, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_lvl_o = s_q.scl_sh[SYNC_STAGES-1];
    assign sda_lvl_o = s_q.sda_sh[SYNC_STAGES-1];
    assign start_o   = scl_lvl_o & s_q.scl_p & s_q.sda_p & ~sda_lvl_o;
    assign stop_o    = scl_lvl_o & s_q.scl_p & ~s_q.sda_p & sda_lvl_o;
    assign rise_o    = scl_lvl_o & ~s_q.scl_p;
    assign fall_o    = ~scl_lvl_o & s_q.scl_p;

endmodule

// File: rtl/i2c_frame_ctl.sv
module i2c_frame_ctl
    import i2c_tgt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl_i,
    input  logic               sda_lvl_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o,
    output logic               ev_ptr_o,
    output logic               ev_data_o,
    output logic [BYTE_W-1:0]  ev_byte_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   bit_cnt;
        logic [BYTE_W-1:0]  shreg;
        logic               ack_ph;
        logic               oe;
        logic               ev_ptr;
        logic               ev_data;
        logic [BYTE_W-1:0]  byte_out;
    } frame_t;

    frame_t f_d, f_q;
    logic   addr_hit;

    assign addr_hit = (f_q.shreg[BYTE_W-1:1] == {DEV_ID_HI, strap_i}) && !f_q.shreg[0];

    always_comb begin
        f_d         = f_q;
        f_d.ev_ptr  = 1'b0;
        f_d.ev_data = 1'b0;
        if (start_i) begin
            f_d.phase   = PH_ADDR;
            f_d.bit_cnt = '0;
            f_d.ack_ph  = 1'b0;
            f_d.oe      = 1'b0;
        end else if (stop_i) begin
            f_d.phase   = PH_IDLE;
            f_d.bit_cnt = '0;
            f_d.ack_ph  = 1'b0;
            f_d.oe      = 1'b0;
        end else if (f_q.phase inside {PH_ADDR, PH_PTR, PH_DATA}) begin
            if (rise_i && !f_q.ack_ph && (f_q.bit_cnt < CNT_W'(BYTE_W))) begin
                f_d.shreg   = {f_q.shreg[BYTE_W-2:0], sda_lvl_i};
                f_d.bit_cnt = f_q.bit_cnt + CNT_W'(1);
            end
            if (fall_i) begin
                if (!f_q.ack_ph && (f_q.bit_cnt == CNT_W'(BYTE_W))) begin
                    if ((f_q.phase == PH_ADDR) && !addr_hit) begin
                        f_d.phase = PH_SKIP;
                    end else begin
                        f_d.ack_ph = 1'b1;
                        f_d.oe     = 1'b1;
                    end
                end else if (f_q.ack_ph) begin
                    f_d.ack_ph   = 1'b0;
                    f_d.oe       = 1'b0;
                    f_d.bit_cnt  = '0;
                    f_d.byte_out = f_q.shreg;
                    unique case (f_q.phase)
                        PH_ADDR: f_d.phase = PH_PTR;
                        PH_PTR: begin
                            f_d.ev_ptr = 1'b1;
                            f_d.phase  = PH_DATA;
                        end
                        default: f_d.ev_data = 1'b1;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{phase: PH_IDLE, bit_cnt: '0, shreg: '0, ack_ph: 1'b0, oe: 1'b0,
                     ev_ptr: 1'b0, ev_data: 1'b0, byte_out: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign sda_oe_o  = f_q.oe;
    assign ev_ptr_o  = f_q.ev_ptr;
    assign ev_data_o = f_q.ev_data;
    assign ev_byte_o = f_q.byte_out;

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.phase == PH_SKIP) |-> !f_q.oe); // R1
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.oe) |-> !scl_lvl_i); // R9
    AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.phase == PH_SKIP) |=> !(ev_ptr_o || ev_data_o)); // R10

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
    import i2c_tgt_pkg::*;
#(
    parameter logic [7:0]  CFG_RST   = 8'h00,
    parameter logic [15:0] HYST_RST  = 16'h4B00,
    parameter logic [15:0] OTEMP_RST = 16'h5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ptr_i,
    input  logic              ev_data_i,
    input  logic [BYTE_W-1:0] ev_byte_i,
    output logic [BYTE_W-1:0] ptr_o,
    output logic [BYTE_W-1:0] cfg_o,
    output logic [15:0]       hyst_o,
    output logic [15:0]       otemp_o
);

    localparam int WIDE_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0]                ptr;
        logic [BYTE_W-1:0]                cfg;
        logic [NUM_WIDE-1:0][WIDE_W-1:0]  wide;
        logic [BYTE_W-1:0]                hi_hold;
        logic [1:0]                       idx;
    } regs_t;

    regs_t r_d, r_q;
    logic  ptr_known;

    always_comb begin
        ptr_known = (r_q.ptr == PTR_CFG);
        for (int k = 0; k < NUM_WIDE; k++) begin
            if (r_q.ptr == PTR_WIDE_BASE + 8'(k)) ptr_known = 1'b1;
        end
    end

    always_comb begin
        r_d = r_q;
        if (ev_ptr_i) begin
            r_d.ptr = ev_byte_i;
            r_d.idx = 2'd0;
        end else if (ev_data_i) begin
            if (r_q.idx != 2'd2) r_d.idx = r_q.idx + 2'd1;
            if ((r_q.ptr == PTR_CFG) && (r_q.idx == 2'd0)) begin
                r_d.cfg = ev_byte_i;
            end
            for (int k = 0; k < NUM_WIDE; k++) begin
                if (r_q.ptr == PTR_WIDE_BASE + 8'(k)) begin
                    if (r_q.idx == 2'd0) begin
                        r_d.hi_hold = ev_byte_i;
                    end else if (r_q.idx == 2'd1) begin
                        r_d.wide[k] = {r_q.hi_hold, ev_byte_i};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ptr: '0, cfg: CFG_RST, wide: {OTEMP_RST, HYST_RST}, hi_hold: '0, idx: 2'd0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ptr_o   = r_q.ptr;
    assign cfg_o   = r_q.cfg;
    assign hyst_o  = r_q.wide[0];
    assign otemp_o = r_q.wide[1];

    AST_PTR_ONLY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ptr_i |=> ($stable(cfg_o) && $stable(hyst_o) && $stable(otemp_o))); // R2
    AST_CFG_SURPLUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_data_i && (r_q.idx != 2'd0)) |=> $stable(cfg_o)); // R5
    AST_UNDEF_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_data_i && !ptr_known) |=> ($stable(cfg_o) && $stable(hyst_o) && $stable(otemp_o))); // R7

    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide_chk
        AST_WIDE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_data_i && (r_q.idx != 2'd1)) |=> $stable(r_q.wide[g])); // R4
    end

endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
    import i2c_tgt_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CFG_RST     = 8'h00,
    parameter logic [15:0] HYST_RST    = 16'h4B00,
    parameter logic [15:0] OTEMP_RST   = 16'h5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [2:0]  strap_i,
    output logic        sda_oe_o,
    output logic [7:0]  ptr_o,
    output logic [7:0]  cfg_o,
    output logic [15:0] hyst_o,
    output logic [15:0] otemp_o
);

    logic              scl_lvl, sda_lvl, cond_start, cond_stop, scl_rise, scl_fall;
    logic              ev_ptr, ev_data;
    logic [BYTE_W-1:0] ev_byte;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl_o(scl_lvl),
        .sda_lvl_o(sda_lvl),
        .start_o  (cond_start),
        .stop_o   (cond_stop),
        .rise_o   (scl_rise),
        .fall_o   (scl_fall)
    );

    i2c_frame_ctl u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl_i(scl_lvl),
        .sda_lvl_i(sda_lvl),
        .start_i  (cond_start),
        .stop_i   (cond_stop),
        .rise_i   (scl_rise),
        .fall_i   (scl_fall),
        .strap_i  (strap_i),
        .sda_oe_o (sda_oe_o),
        .ev_ptr_o (ev_ptr),
        .ev_data_o(ev_data),
        .ev_byte_o(ev_byte)
    );

    i2c_reg_file #(
        .CFG_RST  (CFG_RST),
        .HYST_RST (HYST_RST),
        .OTEMP_RST(OTEMP_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_ptr_i (ev_ptr),
        .ev_data_i(ev_data),
        .ev_byte_i(ev_byte),
        .ptr_o    (ptr_o),
        .cfg_o    (cfg_o),
        .hyst_o   (hyst_o),
        .otemp_o  (otemp_o)
    );

    AST_START_CLEARS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_start || cond_stop) |=> !sda_oe_o); // R6

endmodule

// File: tb/test_i2c_regwr_target.sv
`timescale 1ns/1ps
module test_i2c_regwr_target;

    localparam int Q = 10;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] AW_OK = {4'b1001, STRAP, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [7:0]  ptr, cfg;
    logic [15:0] hyst, otemp;
    wire         sda_bus = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    i2c_regwr_target i_i2c_regwr_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .strap_i (STRAP),
        .sda_oe_o(sda_oe),
        .ptr_o   (ptr),
        .cfg_o   (cfg),
        .hyst_o  (hyst),
        .otemp_o (otemp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
        waitq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitq();
            scl_m = 1'b1; waitq(); waitq();
            scl_m = 1'b0; waitq();
        end
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        acked = ~sda_bus;
        waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic byte_chk(input string req, input logic [7:0] b, input logic exp_ack);
        logic a;
        send_byte(b, a);
        chk(req, {31'd0, a}, {31'd0, exp_ack});
    endtask

    task automatic t_reset();
        chk("R8 cfg", {24'd0, cfg}, 32'h00);
        chk("R8 hyst", {16'd0, hyst}, 32'h4B00);
        chk("R8 otemp", {16'd0, otemp}, 32'h5000);
        chk("R8 ptr", {24'd0, ptr}, 32'h00);
        chk("R8 oe", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic t_cfg_write();
        bus_start();
        byte_chk("R1 addr ack", AW_OK, 1'b1);
        byte_chk("R2 ptr ack", 8'h01, 1'b1);
        byte_chk("R3 data ack", 8'hA5, 1'b1);
        bus_stop();
        chk("R3 cfg", {24'd0, cfg}, 32'hA5);
    endtask

    task automatic t_ptr_only();
        bus_start();
        byte_chk("R1 addr ack", AW_OK, 1'b1);
        byte_chk("R2 ptr ack", 8'h03, 1'b1);
        bus_stop();
        chk("R2 ptr stored", {24'd0, ptr}, 32'h03);
        chk("R2 cfg kept", {24'd0, cfg}, 32'hA5);
        chk("R2 otemp kept", {16'd0, otemp}, 32'h5000);
    endtask

    task automatic t_hyst_write();
        bus_start();
        byte_chk("R1 addr ack", AW_OK, 1'b1);
        byte_chk("R4 ptr ack", 8'h02, 1'b1);
        byte_chk("R4 msb ack", 8'h12, 1'b1);
        byte_chk("R4 lsb ack", 8'h34, 1'b1);
        bus_stop();
        chk("R4 hyst msb first", {16'd0, hyst}, 32'h1234);
        chk("R4 otemp untouched", {16'd0, otemp}, 32'h5000);
    endtask

    task automatic t_partial();
        bus_start();
        byte_chk("R1 addr ack", AW_OK, 1'b1);
        byte_chk("R4 ptr ack", 8'h03, 1'b1);
        byte_chk("R4 half ack", 8'h77, 1'b1);
        bus_stop();
        chk("R4 partial keeps otemp", {16'd0, otemp}, 32'h5000);
    endtask

    task automatic t_surplus();
        bus_start();
        byte_chk("R1 addr ack", AW_OK, 1'b1);
        byte_chk("R5 ptr ack", 8'h03, 1'b1);
        byte_chk("R5 b0 ack", 8'h9A, 1'b1);
        byte_chk("R5 b1 ack", 8'hBC, 1'b1);
        byte_chk("R5 extra ack", 8'hDE, 1'b1);
        byte_chk("R5 extra2 ack", 8'hF0, 1'b1);
        bus_stop();
        chk("R5 otemp first two only", {16'd0, otemp}, 32'h9ABC);
    endtask

    task automatic t_repstart();
        bus_start();
        byte_chk("R1 addr ack", AW_OK, 1'b1);
        byte_chk("R6 ptr ack", 8'h01, 1'b1);
        byte_chk("R6 cfg ack", 8'h5A, 1'b1);
        byte_chk("R5 cfg extra ack", 8'hEE, 1'b1);
        bus_start();
        byte_chk("R6 addr again", AW_OK, 1'b1);
        byte_chk("R6 ptr2 ack", 8'h02, 1'b1);
        byte_chk("R6 hi ack", 8'hAB, 1'b1);
        byte_chk("R6 lo ack", 8'hCD, 1'b1);
        bus_stop();
        chk("R5 cfg after extra", {24'd0, cfg}, 32'h5A);
        chk("R6 hyst after Sr", {16'd0, hyst}, 32'hABCD);
    endtask

    task automatic t_mismatch();
        bus_start();
        byte_chk("R1 wrong addr nack", {4'b1001, 3'b100, 1'b0}, 1'b0);
        byte_chk("R1 ignored ptr nack", 8'h01, 1'b0);
        byte_chk("R1 ignored data nack", 8'h33, 1'b0);
        bus_stop();
        chk("R1 cfg kept", {24'd0, cfg}, 32'h5A);
        chk("R1 ptr kept", {24'd0, ptr}, 32'h02);
    endtask

    task automatic t_read_addr();
        bus_start();
        byte_chk("R10 read addr nack", {4'b1001, STRAP, 1'b1}, 1'b0);
        byte_chk("R10 follow nack", 8'h01, 1'b0);
        bus_stop();
        chk("R10 ptr kept", {24'd0, ptr}, 32'h02);
    endtask

    task automatic t_undef_ptr();
        bus_start();
        byte_chk("R1 addr ack", AW_OK, 1'b1);
        byte_chk("R7 ptr ack", 8'h07, 1'b1);
        byte_chk("R7 data ack", 8'h99, 1'b1);
        byte_chk("R7 data2 ack", 8'h88, 1'b1);
        bus_stop();
        chk("R7 ptr stored", {24'd0, ptr}, 32'h07);
        chk("R7 cfg kept", {24'd0, cfg}, 32'h5A);
        chk("R7 hyst kept", {16'd0, hyst}, 32'hABCD);
        chk("R7 otemp kept", {16'd0, otemp}, 32'h9ABC);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_cfg_write();
        t_ptr_only();
        t_hyst_write();
        t_partial();
        t_surplus();
        t_repstart();
        t_mismatch();
        t_read_addr();
        t_undef_ptr();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule